// File: doc/BRIEF.md
# Rotating-Parity Stripe Write Engine

This block sits between a host-side block request and an array of five storage columns, each modelled as a word-addressed memory port. It turns a logical block address into a column and a row. Each stripe holds four data blocks and one parity block, and the parity block sits in a different column on each successive stripe.

A logical read becomes a single physical read of the data column. A logical write of one block is carried out as a read-modify-write. The engine reads the old data and the old parity together and waits for both answers. It then writes the new data and the new parity, which is the old parity with the old and new data folded in by XOR. It pulses done when both writes have been acknowledged. The engine handles one request at a time and reports busy from acceptance until done.

Top module: `stripe_rmw_engine`

## Requirements
- R1: For logical address A, the stripe number is A / 4, the position inside the stripe is A mod 4 (the low two bits), and the physical row used in every column is the stripe number.
- R2: The parity column of stripe S is 4 - (S mod 5): column 4 for stripe 0, one column lower on each following stripe, back to column 4 after column 0.
- R3: Data blocks fill the non-parity columns of a stripe in ascending order. Position P goes to column P when P is below the parity column and to column P+1 otherwise.
- R4: A write produces exactly four physical operations: reads of the data column and the parity column, issued in the same cycle, then writes to those same two columns. Each column request lasts one cycle.
- R5: No physical write is issued until both read responses of that request have arrived, and reads and writes are never requested in the same cycle.
- R6: The data column receives the new word, and the parity column receives old parity XOR old data XOR new data, so every stripe stays with the XOR of its five columns equal to zero.
- R7: A read produces one physical read of the data column, and rd_data carries that word while done is high.
- R8: A request is accepted only while busy is low. busy is high from the cycle after acceptance through the done cycle. A request presented while busy has no effect.
- R9: done is a one-cycle pulse and falls together with busy. The last response is sampled at clock edge E, and done is high in the cycle that follows E. A read therefore completes 2 + Ld edges after acceptance and a write 4 + 2*max(Ld, Lp) edges after acceptance, where Ld and Lp are the column response latencies.
- R10: While reset is held low, busy, done and all column request valids are low.

Column c uses bit c of each per-column bit vector, bits [c*6 +: 6] of col_req_row, and bits [c*32 +: 32] of the column data buses. A column request is a one-cycle valid pulse. Its response, for a read or a write, is a one-cycle rsp_valid pulse issued some cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Logical request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lba | input | 8 | Logical block address |
| req_wdata | input | 32 | New data word for a write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Data word of a logical read, valid with done |
| col_req_valid | output | 5 | Per-column request strobe |
| col_req_write | output | 5 | Per-column request direction, 1 = write |
| col_req_row | output | 30 | Per-column row address, 6 bits per column |
| col_req_wdata | output | 160 | Per-column write data, 32 bits per column |
| col_rsp_valid | input | 5 | Per-column response strobe (read data or write acknowledge) |
| col_rsp_rdata | input | 160 | Per-column read data, 32 bits per column |

## Verification
The column models in the bench answer after a fixed latency that differs per column. Each completion therefore has an exact due edge: 2 + Ld edges after acceptance for a read, and 4 + 2*max(Ld, Lp) for a write. The bench records the edge count at acceptance and at the first sample where done is high, and compares the difference with that formula. It then looks one cycle later to confirm that done and busy have both dropped. Column requests are logged on the same edges at which the design presents them, so the same-cycle issue of both reads, the wait for both reads before any write, and the exact set of columns touched are checked against counts taken in the cycles where they happen.

// File: rtl/stripe_rmw_pkg.sv
package stripe_rmw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ISSUE,
      ST_RD_WAIT,
      ST_WR_ISSUE,
      ST_WR_WAIT,
      ST_DONE
   } eng_state_t;

endpackage

// File: rtl/stripe_map.sv
module stripe_map #(
   parameter int LBA_W    = 8,
   parameter int NUM_DATA = 4,
   localparam int NUM_COLS = NUM_DATA + 1,
   localparam int IDX_W    = $clog2(NUM_DATA),
   localparam int COL_W    = $clog2(NUM_COLS),
   localparam int ROW_W    = LBA_W - IDX_W
) (
   input  logic [LBA_W-1:0] lba,
   output logic [ROW_W-1:0] row,
   output logic [COL_W-1:0] data_col,
   output logic [COL_W-1:0] parity_col
);

   logic [IDX_W-1:0] slot;
   logic [COL_W-1:0] slot_col;
   logic [COL_W-1:0] turn;

   // stripe number doubles as the row inside every column
   assign row      = lba[LBA_W-1:IDX_W];
   assign slot     = lba[IDX_W-1:0];
   assign slot_col = COL_W'(slot);

   // parity steps one column lower per stripe, wrapping at column 0
   assign turn       = COL_W'(row % ROW_W'(NUM_COLS));
   assign parity_col = COL_W'(NUM_COLS - 1) - turn;

   // data skips over the parity column
   assign data_col = (slot_col < parity_col) ? slot_col : slot_col + COL_W'(1);

endmodule

// File: rtl/rsp_slot.sv
module rsp_slot #(
   parameter int DATA_W   = 32,
   parameter int NUM_COLS = 5,
   localparam int COL_W   = $clog2(NUM_COLS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       arm,
   input  logic                       load,
   input  logic [COL_W-1:0]           sel,
   input  logic [NUM_COLS-1:0]        rsp_valid,
   input  logic [NUM_COLS*DATA_W-1:0] rsp_data,
   output logic                       got_next,
   output logic [DATA_W-1:0]          data
);

   logic got;
   logic hit;

   assign hit      = arm & rsp_valid[sel];
   assign got_next = got | hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         got  <= 1'b0;
         data <= '0;
      end else begin
         if (clear)
            got <= 1'b0;
         else if (hit)
            got <= 1'b1;
         if (hit && load)
            data <= rsp_data[sel*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/stripe_rmw_engine.sv
module stripe_rmw_engine
   import stripe_rmw_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int LBA_W    = 8,
   parameter int NUM_DATA = 4,
   localparam int NUM_COLS = NUM_DATA + 1,
   localparam int IDX_W    = $clog2(NUM_DATA),
   localparam int COL_W    = $clog2(NUM_COLS),
   localparam int ROW_W    = LBA_W - IDX_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic [LBA_W-1:0]           req_lba,
   input  logic [DATA_W-1:0]          req_wdata,
   output logic                       busy,
   output logic                       done,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_COLS-1:0]        col_req_valid,
   output logic [NUM_COLS-1:0]        col_req_write,
   output logic [NUM_COLS*ROW_W-1:0]  col_req_row,
   output logic [NUM_COLS*DATA_W-1:0] col_req_wdata,
   input  logic [NUM_COLS-1:0]        col_rsp_valid,
   input  logic [NUM_COLS*DATA_W-1:0] col_rsp_rdata
);

   // elaboration-time parameter checks
   if (NUM_DATA < 2 || (NUM_DATA & (NUM_DATA - 1)) != 0) begin : g_bad_ndata
      $error("NUM_DATA must be a power of two, at least 2");
   end
   if (ROW_W <= COL_W) begin : g_bad_lba
      $error("LBA_W too narrow for the stripe rotation");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   eng_state_t       st;
   logic             is_wr_q;
   logic [COL_W-1:0] dcol_q, pcol_q;
   logic [ROW_W-1:0] row_q;
   logic [DATA_W-1:0] wdata_q;

   logic [ROW_W-1:0] map_row;
   logic [COL_W-1:0] map_dcol, map_pcol;

   logic             got_nx   [2];
   logic [DATA_W-1:0] slot_data [2];
   logic [DATA_W-1:0] new_par;
   logic             issuing, waiting;

   stripe_map #(
      .LBA_W   (LBA_W),
      .NUM_DATA(NUM_DATA)
   ) u_map (
      .lba       (req_lba),
      .row       (map_row),
      .data_col  (map_dcol),
      .parity_col(map_pcol)
   );

   assign issuing = (st == ST_RD_ISSUE) || (st == ST_WR_ISSUE);
   assign waiting = (st == ST_RD_WAIT)  || (st == ST_WR_WAIT);

   // slot 0 follows the data column, slot 1 the parity column
   for (genvar s = 0; s < 2; s++) begin : g_slot
      rsp_slot #(
         .DATA_W  (DATA_W),
         .NUM_COLS(NUM_COLS)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear    (issuing),
         .arm      (waiting && (s == 0 || is_wr_q)),
         .load     (st == ST_RD_WAIT),
         .sel      ((s == 0) ? dcol_q : pcol_q),
         .rsp_valid(col_rsp_valid),
         .rsp_data (col_rsp_rdata),
         .got_next (got_nx[s]),
         .data     (slot_data[s])
      );
   end

   assign new_par = slot_data[1] ^ slot_data[0] ^ wdata_q;

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      logic on_data, on_par;
      assign on_data = (dcol_q == COL_W'(c));
      assign on_par  = (pcol_q == COL_W'(c)) && is_wr_q;
      assign col_req_valid[c] = issuing && (on_data || on_par);
      assign col_req_write[c] = (st == ST_WR_ISSUE);
      assign col_req_row[c*ROW_W +: ROW_W]    = row_q;
      assign col_req_wdata[c*DATA_W +: DATA_W] = on_par ? new_par : wdata_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         is_wr_q <= 1'b0;
         dcol_q  <= '0;
         pcol_q  <= '0;
         row_q   <= '0;
         wdata_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  is_wr_q <= req_write;
                  dcol_q  <= map_dcol;
                  pcol_q  <= map_pcol;
                  row_q   <= map_row;
                  wdata_q <= req_wdata;
                  st      <= ST_RD_ISSUE;
               end
            end
            ST_RD_ISSUE: st <= ST_RD_WAIT;
            ST_RD_WAIT: begin
               if (got_nx[0] && (got_nx[1] || !is_wr_q))
                  st <= is_wr_q ? ST_WR_ISSUE : ST_DONE;
            end
            ST_WR_ISSUE: st <= ST_WR_WAIT;
            ST_WR_WAIT: begin
               if (got_nx[0] && got_nx[1])
                  st <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st != ST_IDLE);
   assign done    = (st == ST_DONE);
   assign rd_data = slot_data[0];

endmodule

// File: rtl/stripe_rmw_engine_chk.sv
module stripe_rmw_engine_chk #(
   parameter int NUM_COLS = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                busy,
   input logic                done,
   input logic [NUM_COLS-1:0] col_req_valid,
   input logic [NUM_COLS-1:0] col_req_write
);

   assert_reset_quiet_R10: assert property (@(posedge clk)
      !rst_n |-> (!busy && !done));

   assert_idle_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (col_req_valid == '0));

   assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_two_at_most_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col_req_valid) <= 2);

   assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|col_req_valid) |=> (col_req_valid == '0));

   assert_no_mix_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(col_req_valid & col_req_write)) |-> ((col_req_valid & ~col_req_write) == '0));

   assert_no_early_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(col_req_valid & ~col_req_write)) |=> !(|(col_req_valid & col_req_write)));

endmodule

bind stripe_rmw_engine stripe_rmw_engine_chk #(
   .NUM_COLS(NUM_COLS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .busy         (busy),
   .done         (done),
   .col_req_valid(col_req_valid),
   .col_req_write(col_req_write)
);

// File: tb/stripe_rmw_engine_tb_top.sv
module stripe_rmw_engine_tb_top;

   localparam int DW = 32;
   localparam int LW = 8;
   localparam int NC = 5;
   localparam int RW = 6;
   localparam int NR = 64;
   localparam int NL = 256;
   localparam int NV = 17;

   // {write, lba, data}
   localparam logic [40:0] VEC [NV] = '{
      {1'b1, 8'd0,   32'h1111_0001},
      {1'b1, 8'd3,   32'h2222_0003},
      {1'b1, 8'd7,   32'h3333_0007},
      {1'b0, 8'd7,   32'h0000_0000},
      {1'b1, 8'd6,   32'h4444_0006},
      {1'b1, 8'd9,   32'h5555_0009},
      {1'b1, 8'd10,  32'h6666_000A},
      {1'b0, 8'd10,  32'h0000_0000},
      {1'b1, 8'd13,  32'h7777_000D},
      {1'b1, 8'd16,  32'h8888_0010},
      {1'b1, 8'd19,  32'h9999_0013},
      {1'b1, 8'd20,  32'hAAAA_0014},
      {1'b0, 8'd20,  32'h0000_0000},
      {1'b1, 8'd255, 32'hBBBB_00FF},
      {1'b0, 8'd255, 32'h0000_0000},
      {1'b1, 8'd3,   32'hCCCC_1003},
      {1'b0, 8'd1,   32'h0000_0000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_write = 1'b0;
   logic [LW-1:0] req_lba = '0;
   logic [DW-1:0] req_wdata = '0;
   logic busy, done;
   logic [DW-1:0] rd_data;
   logic [NC-1:0] col_req_valid, col_req_write, col_rsp_valid;
   logic [NC*RW-1:0] col_req_row;
   logic [NC*DW-1:0] col_req_wdata, col_rsp_rdata;

   always #5 clk = ~clk;

   stripe_rmw_engine dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_lba      (req_lba),
      .req_wdata    (req_wdata),
      .busy         (busy),
      .done         (done),
      .rd_data      (rd_data),
      .col_req_valid(col_req_valid),
      .col_req_write(col_req_write),
      .col_req_row  (col_req_row),
      .col_req_wdata(col_req_wdata),
      .col_rsp_valid(col_rsp_valid),
      .col_rsp_rdata(col_rsp_rdata)
   );

   // column storage models
   logic [DW-1:0] mem [NC][NR];
   int            cnt [NC];
   logic          p_wr [NC];
   logic [RW-1:0] p_row [NC];
   logic [DW-1:0] p_wd [NC];
   logic [DW-1:0] rsp_d [NC];
   logic [NC-1:0] rsp_v = '0;

   int            col_of [NL];
   logic [DW-1:0] shadow [NL];

   int cyc = 0, ops = 0, wr_mask = 0, rd_mask = 0, reads_out = 0;
   int order_err = 0, rd_first = -1, rd_last = -1;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   function automatic int lat(int c);
      return 1 + ((c * 3) % 4);
   endfunction

   function automatic int par_col(int s);
      return 4 - (s % 5);
   endfunction

   assign col_rsp_valid = rsp_v;
   always_comb
      for (int c = 0; c < NC; c++) col_rsp_rdata[c*DW +: DW] = rsp_d[c];

   always @(posedge clk) begin
      cyc++;
      for (int c = 0; c < NC; c++) begin
         if (col_req_valid[c]) begin
            ops++;
            if (col_req_write[c]) begin
               wr_mask |= (1 << c);
               if (reads_out != 0) order_err++;
            end else begin
               rd_mask |= (1 << c);
               reads_out++;
               if (rd_first < 0) rd_first = cyc;
               rd_last = cyc;
            end
         end
      end
      for (int c = 0; c < NC; c++)
         if (rsp_v[c] && !p_wr[c]) reads_out--;
      for (int c = 0; c < NC; c++) begin
         rsp_v[c] <= 1'b0;
         if (col_req_valid[c]) begin
            cnt[c]   <= lat(c);
            p_wr[c]  <= col_req_write[c];
            p_row[c] <= col_req_row[c*RW +: RW];
            p_wd[c]  <= col_req_wdata[c*DW +: DW];
         end else if (cnt[c] == 1) begin
            cnt[c]   <= 0;
            rsp_v[c] <= 1'b1;
            rsp_d[c] <= mem[c][p_row[c]];
            if (p_wr[c]) mem[c][p_row[c]] <= p_wd[c];
         end else if (cnt[c] > 1) begin
            cnt[c] <= cnt[c] - 1;
         end
      end
   end

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   function automatic logic [DW-1:0] stripe_xor(int s);
      logic [DW-1:0] x = '0;
      for (int c = 0; c < NC; c++) x ^= mem[c][s];
      return x;
   endfunction

   task automatic do_op(bit w, int l, logic [DW-1:0] d, bit poke, int poke_lba);
      int a, n, s, dc, pc, due, lmax;
      @(negedge clk);
      ops = 0; wr_mask = 0; rd_mask = 0; order_err = 0;
      rd_first = -1; rd_last = -1;
      req_valid = 1'b1; req_write = w; req_lba = LW'(l); req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      a = cyc;
      check(busy == 1'b1, "R8", "busy after accept", longint'(busy), 1);
      if (poke) begin
         // R8: a request while busy must be ignored
         req_valid = 1'b1; req_write = 1'b1; req_lba = LW'(poke_lba);
         req_wdata = 32'hDEAD_BEEF;
         repeat (3) @(negedge clk);
         req_valid = 1'b0;
      end
      n = 0;
      while (!done && n < 500) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         check(1'b0, "R9", "done never arrived", 0, 1);
         return;
      end
      s  = l / 4;
      dc = col_of[l];
      pc = par_col(s);
      lmax = (lat(dc) > lat(pc)) ? lat(dc) : lat(pc);
      due = w ? (4 + 2 * lmax) : (2 + lat(dc));
      check((cyc - a) == due, "R9", "done latency", cyc - a, due);
      if (w) begin
         shadow[l] = d;
         check(mem[dc][s] == d, "R1", "data at column/row", mem[dc][s], d);
         check(stripe_xor(s) == '0, "R6", "stripe parity", stripe_xor(s), 0);
         check(ops == 4, "R4", "physical op count", ops, 4);
         check(rd_first == rd_last, "R4", "reads same cycle", rd_last, rd_first);
         check(order_err == 0, "R5", "write before reads done", order_err, 0);
         check(wr_mask == ((1 << dc) | (1 << pc)), "R2", "written columns",
               wr_mask, (1 << dc) | (1 << pc));
         check(rd_mask == ((1 << dc) | (1 << pc)), "R3", "read columns",
               rd_mask, (1 << dc) | (1 << pc));
      end else begin
         check(rd_data == shadow[l], "R7", "read data", rd_data, shadow[l]);
         check(ops == 1, "R7", "read op count", ops, 1);
         check(rd_mask == (1 << dc), "R3", "read column", rd_mask, 1 << dc);
      end
      @(negedge clk);
      check(!done && !busy, "R9", "done pulse width", {done, busy}, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "WATCHDOG", "run timed out", cyc, 0);
      finish_run();
   end

   initial begin
      // fill every stripe with a consistent pattern, walking column by column
      for (int s = 0; s < NR; s++) begin
         int k;
         logic [DW-1:0] px;
         k = 0;
         px = '0;
         for (int c = 0; c < NC; c++) begin
            if (c != par_col(s)) begin
               int l;
               l = s * 4 + k;
               col_of[l] = c;
               shadow[l] = 32'h5A5A_0000 ^ (DW'(l) * 32'h0001_0203);
               mem[c][s] = shadow[l];
               px ^= shadow[l];
               k++;
            end
         end
         mem[par_col(s)][s] = px;
      end
      for (int c = 0; c < NC; c++) begin
         cnt[c] = 0; p_wr[c] = 1'b0; p_row[c] = '0; p_wd[c] = '0; rsp_d[c] = '0;
      end

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!busy && !done && col_req_valid == '0, "R10", "reset outputs",
            {busy, done, col_req_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy, "R10", "idle after reset", busy, 0);

      for (int v = 0; v < NV; v++)
         do_op(VEC[v][40], int'(VEC[v][39:32]), VEC[v][31:0], 1'b0, 0);

      // directed: request while busy is ignored (R8)
      do_op(1'b1, 40, 32'hF00D_0028, 1'b1, 41);
      check(mem[col_of[41]][10] == shadow[41], "R8", "ignored write left data",
            mem[col_of[41]][10], shadow[41]);
      check(stripe_xor(10) == '0, "R6", "stripe 10 parity", stripe_xor(10), 0);
      do_op(1'b0, 41, '0, 1'b0, 0);

      // directed: wrap of parity column, stripe 5 and stripe 4 boundaries
      do_op(1'b1, 23, 32'h0BAD_0017, 1'b0, 0);
      do_op(1'b1, 17, 32'h0BAD_0011, 1'b0, 0);
      do_op(1'b0, 17, '0, 1'b0, 0);

      finish_run();
   end

endmodule